// File: doc/BRIEF.md
# Burst Column Address Generator

This block keeps a local copy of the SDRAM mode settings and produces, one cycle per beat, the column address of each beat in a read or write burst. A controller loads the 7-bit mode field and the single-write bit. It then pulses a start input with the first column and a read/write flag. The block returns the current column together with a beat-valid flag and a last-beat flag until the burst runs out. A terminate input stops the burst early.

The burst length, the beat ordering (sequential wrap or XOR interleave), the open-ended full-page mode and the single-write override are handled here. The CAS latency code is decoded into a cycle count and exported for the data path, which is built elsewhere. Each burst takes its shape from the mode at the moment it starts.

Top module: `burst_colgen`

## Requirements
- R1: After reset the held mode is burst length code 000, sequential ordering and CAS code 010. A mode load is visible from the cycle after the load edge. mode_in[2:0] is the length code, mode_in[3] the ordering (0 sequential, 1 interleaved) and mode_in[6:4] the CAS code. CAS code 010 gives cas_cycles=2 and code 011 gives cas_cycles=3.
- R2: With length codes 000, 001, 010 and 011 a burst has 1, 2, 4 and 8 beats. beat_valid first rises in the cycle after the start edge, and that first beat's column equals start_col.
- R3: In sequential order, beat i has column start_col with its low log2(BL) bits replaced by (start_col + i) mod BL. This wraps inside the aligned block, and the upper bits are unchanged.
- R4: In interleaved order, beat i has column start_col with its low log2(BL) bits replaced by those bits XOR i.
- R5: Length code 111 with sequential order is full page. The column counts up from start_col through all 512 values, wrapping from 511 to 0. beat_last stays low, and the burst continues until a terminate or a new start.
- R6: Length codes 100, 101, 110, and code 111 with interleaved order, set mode_err and give bursts of exactly 1 beat. A CAS code other than 010 or 011 sets mode_err and gives cas_cycles=0.
- R7: When the write-mode bit is 1, a burst started with start_write=1 has exactly 1 beat, while a read burst keeps the programmed length. When the bit is 0, writes use the programmed length.
- R8: The beat shown in the cycle where term is high is the last one. beat_valid is low in the next cycle.
- R9: beat_last is high exactly on the final beat of a finite burst, and beat_valid is low in the cycle after it unless a new burst starts.
- R10: A start during a running burst begins the new burst at once and wins over a simultaneous term. A mode load during a running burst does not change that burst's length or order.
- R11: After reset, beat_valid and beat_last are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_load | input | 1 | Capture mode_in and wmode_in this edge |
| mode_in | input | 7 | Length code [2:0], ordering [3], CAS code [6:4] |
| wmode_in | input | 1 | 1 = writes are single-beat |
| start | input | 1 | Begin a burst this edge |
| start_write | input | 1 | 1 = the starting burst is a write |
| start_col | input | 9 | First column of the burst |
| term | input | 1 | End the current burst after this cycle's beat |
| col | output | 9 | Column of the current beat (0 when idle) |
| beat_valid | output | 1 | A beat is presented this cycle |
| beat_last | output | 1 | This beat is the final one of a finite burst |
| cas_cycles | output | 3 | Decoded CAS latency, 0 if the code is reserved |
| mode_err | output | 1 | Held mode contains a reserved code |

## Verification
Sequential and interleaved bursts start from columns that are not aligned, such as 0x1FD and 0x005. A wrong wrap point and a confused XOR-versus-add ordering then give different columns on the same beat. Every length code is run from one unaligned base, so a mixed-up length shows up as a wrong beat count or a misplaced last flag. A full-page burst is run across the 511-to-0 boundary for more than 512 beats. Terminate, restart-over-terminate, a mode load mid-burst, and writes with the single-write bit set and cleared each separate one control path from the others.

// File: rtl/burst_colgen_pkg.sv
// Shared types and constants for the burst column generator.
package burst_colgen_pkg;

    localparam int MODE_W  = 7;   // length[2:0], ordering[3], CAS[6:4]
    localparam int LG_W    = 2;   // log2 of finite burst length (0..3)
    localparam int CAS_W   = 3;

    // Shape of a burst as seen by the sequencer and the orderer.
    typedef struct packed {
        logic            full;    // open-ended full-page burst
        logic [LG_W-1:0] lg;      // log2(beats) for finite bursts
        logic            inter;   // 1 = XOR ordering
    } shape_t;

endpackage

// File: rtl/bcg_mode_reg.sv
// Holds the programmed mode and decodes it into a burst shape, a CAS cycle
// count and an error flag. Assumes loads come from a controller that only
// loads when it wants the new mode for the next burst it starts.
module bcg_mode_reg
    import burst_colgen_pkg::*;
#(
    parameter logic [MODE_W-1:0] RESET_MODE = 7'b010_0_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MODE_W-1:0] mode_in,
    input  logic              wmode_in,
    output shape_t            shape,
    output logic              wr_single,
    output logic [CAS_W-1:0]  cas_cycles,
    output logic              mode_err
);

    logic [MODE_W-1:0] mode_q;
    logic              wmode_q;
    logic              bl_err;
    logic              cas_err;

    // Mode storage: capture on load, reset to the default mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= RESET_MODE;
            wmode_q <= 1'b0;
        end else if (load) begin
            mode_q  <= mode_in;
            wmode_q <= wmode_in;
        end
    end

    // Length and ordering decode; reserved combinations fall back to one beat.
    always_comb begin
        shape.inter = mode_q[3];
        shape.full  = 1'b0;
        shape.lg    = '0;
        bl_err      = 1'b0;
        case (mode_q[2:0])
            3'b000, 3'b001, 3'b010, 3'b011: shape.lg = mode_q[LG_W-1:0];
            3'b111: begin
                if (!mode_q[3]) shape.full = 1'b1;
                else            bl_err     = 1'b1;
            end
            default: bl_err = 1'b1;
        endcase
    end

    // CAS latency decode; reserved codes export zero.
    always_comb begin
        cas_err = 1'b0;
        case (mode_q[6:4])
            3'b010:  cas_cycles = 3'd2;
            3'b011:  cas_cycles = 3'd3;
            default: begin
                cas_cycles = '0;
                cas_err    = 1'b1;
            end
        endcase
    end

    assign wr_single = wmode_q;
    assign mode_err  = bl_err | cas_err;

    p_cas_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_cycles == 3'd0) || (cas_cycles == 3'd2) || (cas_cycles == 3'd3));

    p_cas_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_cycles == 3'd0) |-> mode_err);

endmodule

// File: rtl/bcg_beat_ctr.sv
// Burst sequencer: latches the start column and the burst shape at start,
// counts beats, and ends the burst on its final beat or on terminate.
// Assumes start wins over term when both arrive in one cycle.
module bcg_beat_ctr
    import burst_colgen_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_write,
    input  logic [COL_W-1:0] start_col,
    input  logic             term,
    input  shape_t           shape_in,
    input  logic             wr_single,
    output logic             active,
    output logic [COL_W-1:0] cnt,
    output logic [COL_W-1:0] base,
    output shape_t           shape_q,
    output logic             last
);

    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    shape_t           shape_eff;
    logic [COL_W-1:0] beat_lim;

    // Shape for a new burst: a write in single-write mode collapses to one beat.
    always_comb begin
        shape_eff = shape_in;
        if (start_write && wr_single) begin
            shape_eff.full = 1'b0;
            shape_eff.lg   = '0;
        end
    end

    // Index of the final beat of a finite burst.
    assign beat_lim = (ONE << shape_q.lg) - ONE;
    assign last     = active && !shape_q.full && (cnt == beat_lim);

    // Burst state: start loads, each beat advances, last or term stops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            cnt     <= '0;
            base    <= '0;
            shape_q <= '0;
        end else if (start) begin
            active  <= 1'b1;
            cnt     <= '0;
            base    <= start_col;
            shape_q <= shape_eff;
        end else if (active) begin
            if (term || last) active <= 1'b0;
            else              cnt    <= cnt + ONE;
        end
    end

    p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !start && !term && !last) |=> (active && cnt == $past(cnt) + ONE));

    p_hold_shape_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !start) |=> $stable(shape_q));

endmodule

// File: rtl/bcg_col_order.sv
// Beat-to-column mapping. Bits under the burst mask come from either the
// wrapped sum or the XOR of base and beat index; bits above it keep the base.
// Assumes interleaved order is never combined with full page.
module bcg_col_order
    import burst_colgen_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] cnt,
    input  shape_t           shape,
    output logic [COL_W-1:0] col
);

    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    logic [COL_W-1:0] mask;
    logic [COL_W-1:0] seq_sum;
    logic [COL_W-1:0] xor_val;

    // Mask of the bits that move within the burst.
    assign mask    = shape.full ? '1 : ((ONE << shape.lg) - ONE);
    assign seq_sum = base + cnt;
    assign xor_val = base ^ cnt;

    // Per-bit selection between fixed, wrapped-sum and XOR bits.
    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        assign col[i] = !mask[i]    ? base[i]
                      : shape.inter ? xor_val[i]
                      :               seq_sum[i];
    end

endmodule

// File: rtl/burst_colgen.sv
// Top of the burst column generator: mode storage, burst sequencer and
// column ordering. Outputs reflect registered state only; a start shows its
// first beat one cycle later.
module burst_colgen
    import burst_colgen_pkg::*;
#(
    parameter int                COL_W      = 9,
    parameter logic [MODE_W-1:0] RESET_MODE = 7'b010_0_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_load,
    input  logic [MODE_W-1:0] mode_in,
    input  logic              wmode_in,
    input  logic              start,
    input  logic              start_write,
    input  logic [COL_W-1:0]  start_col,
    input  logic              term,
    output logic [COL_W-1:0]  col,
    output logic              beat_valid,
    output logic              beat_last,
    output logic [CAS_W-1:0]  cas_cycles,
    output logic              mode_err
);

    shape_t           shape_mode;
    shape_t           shape_run;
    logic             wr_single;
    logic             active;
    logic             last;
    logic [COL_W-1:0] cnt;
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] col_raw;

    bcg_mode_reg #(.RESET_MODE(RESET_MODE)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (mode_load),
        .mode_in    (mode_in),
        .wmode_in   (wmode_in),
        .shape      (shape_mode),
        .wr_single  (wr_single),
        .cas_cycles (cas_cycles),
        .mode_err   (mode_err)
    );

    bcg_beat_ctr #(.COL_W(COL_W)) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_write (start_write),
        .start_col   (start_col),
        .term        (term),
        .shape_in    (shape_mode),
        .wr_single   (wr_single),
        .active      (active),
        .cnt         (cnt),
        .base        (base),
        .shape_q     (shape_run),
        .last        (last)
    );

    bcg_col_order #(.COL_W(COL_W)) u_ord (
        .base  (base),
        .cnt   (cnt),
        .shape (shape_run),
        .col   (col_raw)
    );

    // Output stage: column only while a beat is presented.
    assign col        = active ? col_raw : '0;
    assign beat_valid = active;
    assign beat_last  = last;

    p_first_col_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (beat_valid && col == $past(start_col)));

    p_term_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (term && !start) |=> !beat_valid);

    p_last_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_last && !start) |=> !beat_valid);

    p_last_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> beat_valid);

endmodule

// File: tb/burst_colgen_tb.sv
module burst_colgen_tb;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mode_load;
    logic [6:0] mode_in;
    logic       wmode_in;
    logic       start;
    logic       start_write;
    logic [8:0] start_col;
    logic       term;
    logic [8:0] col;
    logic       beat_valid;
    logic       beat_last;
    logic [2:0] cas_cycles;
    logic       mode_err;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    burst_colgen u_dut (
        .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_in(mode_in),
        .wmode_in(wmode_in), .start(start), .start_write(start_write),
        .start_col(start_col), .term(term), .col(col), .beat_valid(beat_valid),
        .beat_last(beat_last), .cas_cycles(cas_cycles), .mode_err(mode_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] exp_col(input logic [8:0] b, input int i,
                                           input int k, input bit il);
        logic [8:0] m, lo;
        m  = (k >= 9) ? 9'h1FF : 9'((1 << k) - 1);
        lo = il ? (b ^ 9'(i)) : (b + 9'(i));
        return (b & ~m) | (lo & m);
    endfunction

    // Load a mode; called at a negedge, returns at a negedge with it in effect.
    task automatic load_mode(input logic [2:0] bl, input bit bt,
                             input logic [2:0] cl, input bit wm);
        mode_load = 1'b1;
        mode_in   = {cl, bt, bl};
        wmode_in  = wm;
        @(negedge clk);
        mode_load = 1'b0;
    endtask

    // Run a burst and check n beats; k = log2 width of moving bits (9 = full).
    task automatic run_burst(input string req, input logic [8:0] c, input bit wr,
                             input int n, input int k, input bit il, input bit full);
        start = 1'b1; start_write = wr; start_col = c;
        @(negedge clk);
        start = 1'b0; start_write = 1'b0;
        for (int i = 0; i < n; i++) begin
            check({req, " valid"}, beat_valid, 1);
            check({req, " col"}, col, exp_col(c, i, k, il));
            check({req, " last"}, beat_last, (!full && i == n - 1) ? 1 : 0);
            if (full && i == n - 1) term = 1'b1;
            @(negedge clk);
        end
        term = 1'b0;
        check({req, " end"}, beat_valid, 0);
    endtask

    task automatic t_reset;
        check("R11 valid", beat_valid, 0);
        check("R11 last", beat_last, 0);
        check("R1 reset cas", cas_cycles, 2);
        check("R1 reset err", mode_err, 0);
        run_burst("R1 reset BL1", 9'h033, 1'b0, 1, 0, 1'b0, 1'b0);
    endtask

    task automatic t_lengths;
        for (int code = 0; code < 4; code++) begin
            load_mode(3'(code), 1'b0, 3'b011, 1'b0);
            check("R1 cas3", cas_cycles, 3);
            run_burst("R2 R9 length", 9'h0A5, 1'b0, 1 << code, code, 1'b0, 1'b0);
        end
    endtask

    task automatic t_seq;
        load_mode(3'b011, 1'b0, 3'b010, 1'b0);
        run_burst("R3 seq8 wrap", 9'h1FD, 1'b0, 8, 3, 1'b0, 1'b0);
        load_mode(3'b010, 1'b0, 3'b010, 1'b0);
        run_burst("R3 seq4", 9'h106, 1'b0, 4, 2, 1'b0, 1'b0);
    endtask

    task automatic t_inter;
        load_mode(3'b011, 1'b1, 3'b010, 1'b0);
        run_burst("R4 int8", 9'h005, 1'b0, 8, 3, 1'b1, 1'b0);
        load_mode(3'b010, 1'b1, 3'b010, 1'b0);
        run_burst("R4 int4", 9'h0F6, 1'b0, 4, 2, 1'b1, 1'b0);
    endtask

    task automatic t_full;
        load_mode(3'b111, 1'b0, 3'b010, 1'b0);
        check("R5 full err", mode_err, 0);
        run_burst("R5 R8 full", 9'h1FE, 1'b0, 520, 9, 1'b0, 1'b1);
    endtask

    task automatic t_reserved;
        for (int code = 4; code < 7; code++) begin
            load_mode(3'(code), 1'b0, 3'b010, 1'b0);
            check("R6 err bl", mode_err, 1);
            run_burst("R6 reserved", 9'h0C3, 1'b0, 1, 0, 1'b0, 1'b0);
        end
        load_mode(3'b111, 1'b1, 3'b010, 1'b0);
        check("R6 err full-int", mode_err, 1);
        run_burst("R6 full-int", 9'h0C3, 1'b0, 1, 0, 1'b1, 1'b0);
        load_mode(3'b010, 1'b0, 3'b000, 1'b0);
        check("R6 cas rsv", cas_cycles, 0);
        check("R6 cas err", mode_err, 1);
        load_mode(3'b010, 1'b0, 3'b110, 1'b0);
        check("R6 cas rsv2", cas_cycles, 0);
    endtask

    task automatic t_wmode;
        load_mode(3'b011, 1'b0, 3'b010, 1'b1);
        run_burst("R7 single write", 9'h012, 1'b1, 1, 0, 1'b0, 1'b0);
        run_burst("R7 read full len", 9'h012, 1'b0, 8, 3, 1'b0, 1'b0);
        load_mode(3'b011, 1'b0, 3'b010, 1'b0);
        run_burst("R7 burst write", 9'h012, 1'b1, 8, 3, 1'b0, 1'b0);
    endtask

    task automatic t_term;
        load_mode(3'b011, 1'b0, 3'b010, 1'b0);
        start = 1'b1; start_col = 9'h020;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk); @(negedge clk);
        term = 1'b1;
        check("R8 beat during term", beat_valid, 1);
        check("R8 col during term", col, 9'h022);
        @(negedge clk);
        term = 1'b0;
        check("R8 stopped", beat_valid, 0);
    endtask

    task automatic t_restart;
        load_mode(3'b011, 1'b0, 3'b010, 1'b0);
        start = 1'b1; start_col = 9'h000;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        load_mode(3'b000, 1'b1, 3'b010, 1'b0);  // mid-burst mode change
        check("R10 burst unchanged", col, 9'h002);
        check("R10 still valid", beat_valid, 1);
        load_mode(3'b011, 1'b0, 3'b010, 1'b0);
        check("R10 col beat3", col, 9'h003);
        start = 1'b1; term = 1'b1; start_col = 9'h040;
        @(negedge clk);
        start = 1'b0; term = 1'b0;
        check("R10 restart valid", beat_valid, 1);
        check("R10 restart col", col, 9'h040);
        for (int i = 1; i < 8; i++) @(negedge clk);
        check("R10 restart last", beat_last, 1);
        check("R10 restart col7", col, 9'h047);
        @(negedge clk);
        check("R10 restart end", beat_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R0 watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode_load = 1'b0; mode_in = '0; wmode_in = 1'b0;
        start = 1'b0; start_write = 1'b0; start_col = '0; term = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lengths();
        t_seq();
        t_inter();
        t_full();
        t_reserved();
        t_wmode();
        t_term();
        t_restart();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule